// File: doc/BRIEF.md
# Programmable PLL Divider Controller

This block decides which feedback divider (N) and reference divider (M) values drive two clock PLLs: one for the processor clock and one for the serial-link reference clock. By default both PLLs take their values from a fixed table of 32 operating points. The row comes from a 5-bit strap code that is latched at power-up. For the processor PLL, a 4-bit software select can override the strap code instead. Software can also take direct control ("dial-in" mode). For the processor PLL it supplies both N and M. For the link PLL it supplies N only, and M stays the table value for the strap code.

Software writes to a small register port. A new M value is staged and only takes effect together with the next N write. An N write on its own takes effect at once. Each change of an active divider pair produces a one-cycle update strobe for that PLL, so the PLL sequencer can reprogram it.

A watchdog guards processor dial-in mode. If no register write arrives within the programmed timeout, it raises a fixed-length system reset pulse. It also applies one of four recovery policies to the processor PLL only: restore the previous pair, load a recovery N, return to the table, or do nothing.

Top module: `pll_div_ctrl`

## Requirements
- R1: While `rst_n` is low, all divider outputs, `gear`, both strobes and `sys_rst` are 0. At the first clock edge after release, the outputs take the table row selected by `hw_fsel`, and both strobes pulse together with that load.
- R2: Table row i (0..31) holds gear = 16+i, CPU N = 200+4i, CPU M = 24+(i mod 8), link N = 100+2i and link M = 25+(i mod 4). Register 0 is the control register, with bit0 CPU dial-in enable, bit1 link dial-in enable, bit2 software-select enable and bits[6:3] software code. With bit2 set, the CPU row is the software code zero-extended. With bit2 clear, the CPU row is `hw_fsel`.
- R3: With CPU dial-in enabled, `cpu_n`/`cpu_m` equal the committed dial-in registers. Register 1 is CPU N, bits[8:0], and register 2 is CPU M, bits[6:0]. Both reset to 0.
- R4: A write to register 2 changes no output. The staged M becomes active only with the next register 1 write, in the same cycle as that N.
- R5: A register 1 write with no M staged changes N alone and leaves M as it was.
- R6: Register 3, bits[8:0], is the link dial-in N. It is active only while control bit1 is set. `src_m` is always the link M of the `hw_fsel` row.
- R7: Each output register update that changes `{cpu_n,cpu_m}` or `{src_n,src_m}` raises `cpu_upd` or `src_upd` for exactly one cycle, in the same cycle as the new value. Unchanged values give no strobe.
- R8: The watchdog runs only while its enable (register 4 bit0) and CPU dial-in are both set. Register 4 bits[15:4] hold the timeout T, and any register write reloads the count. `sys_rst` rises T+2 cycles after the last write and stays high for 16 cycles.
- R9: When register 4 bit1 (auto) is set, a timeout restores the CPU N/M pair that was active before the latest CPU N commit.
- R10: With auto clear and register 4 bits[3:2] = 01, a timeout loads the recovery N (register 5, bits[8:0]) and leaves M unchanged.
- R11: With auto clear and bits[3:2] = 10, a timeout clears CPU dial-in enable, so the table row applies again.
- R12: With auto clear and bits[3:2] = 00 or 11, a timeout only pulses `sys_rst` and changes no divider.
- R13: A timeout never changes the link dial-in enable, the link N or the link outputs.
- R14: `gear` is the gear value of the `hw_fsel` row, whatever the software select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register index |
| wr_data | input | 16 | Register write data |
| hw_fsel | input | 5 | Latched strap frequency code |
| cpu_n | output | 9 | Active CPU PLL feedback divider |
| cpu_m | output | 7 | Active CPU PLL reference divider |
| src_n | output | 9 | Active link PLL feedback divider |
| src_m | output | 7 | Active link PLL reference divider |
| gear | output | 8 | Gear constant of the strap row |
| cpu_upd | output | 1 | CPU divider change strobe |
| src_upd | output | 1 | Link divider change strobe |
| sys_rst | output | 1 | System reset pulse from the watchdog |

## Verification
The assertions check these properties on every cycle:
- a dial-in M never moves unless a CPU N commit or an automatic recovery came just before;
- every strobe matches a real change of its output pair, and no pair changes without one;
- every reset pulse starts right after a watchdog expiry;
- hardware recovery drops dial-in mode;
- the link dial-in state is never touched by an expiry.

Some behaviour only the bench scenarios can show:
- the table contents;
- the choice between strap and software select;
- the exact T+2 expiry delay and 16-cycle pulse;
- the correct pair after each of the four recovery policies.

// File: rtl/pll_pkg.sv
// Shared widths, register indices, recovery encodings and the operating-point
// table generator for the PLL divider controller.
package pll_pkg;
    localparam int N_W    = 9;
    localparam int M_W    = 7;
    localparam int G_W    = 8;
    localparam int SEL_W  = 5;
    localparam int SW_W   = 4;
    localparam int ADDR_W = 3;
    localparam int DATA_W = 16;
    localparam int TMO_W  = 12;

    localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
    localparam logic [ADDR_W-1:0] A_CPU_N = 3'd1;
    localparam logic [ADDR_W-1:0] A_CPU_M = 3'd2;
    localparam logic [ADDR_W-1:0] A_SRC_N = 3'd3;
    localparam logic [ADDR_W-1:0] A_WDOG  = 3'd4;
    localparam logic [ADDR_W-1:0] A_REC_N = 3'd5;

    typedef enum logic [1:0] {
        REC_NONE   = 2'b00,
        REC_MANUAL = 2'b01,
        REC_HW     = 2'b10,
        REC_NONE_B = 2'b11
    } rec_mode_e;

    typedef struct packed {
        logic [G_W-1:0] gear;
        logic [N_W-1:0] cpu_n;
        logic [M_W-1:0] cpu_m;
        logic [N_W-1:0] src_n;
        logic [M_W-1:0] src_m;
    } tbl_entry_t;

    // Computes one row of the operating-point table from its index.
    function automatic tbl_entry_t make_entry(input int idx);
        tbl_entry_t e;
        e.gear  = G_W'(16 + idx);
        e.cpu_n = N_W'(200 + 4 * idx);
        e.cpu_m = M_W'(24 + (idx % 8));
        e.src_n = N_W'(100 + 2 * idx);
        e.src_m = M_W'(25 + (idx % 4));
        return e;
    endfunction
endpackage

// File: rtl/pll_freq_table.sv
// Operating-point lookup: a constant table of 2**SEL_W rows, built by a
// generate loop from the package generator and indexed combinationally.
// Assumes sel is a registered or static code; no timing state inside.
module pll_freq_table
    import pll_pkg::*;
#(
    parameter int TSEL_W = SEL_W
) (
    input  logic [TSEL_W-1:0] sel,
    output tbl_entry_t        entry
);
    localparam int ROWS = 1 << TSEL_W;

    tbl_entry_t rom [ROWS];

    // One constant row per table index.
    for (genvar i = 0; i < ROWS; i++) begin : g_row
        assign rom[i] = make_entry(i);
    end

    // Row selection.
    assign entry = rom[sel];
endmodule

// File: rtl/pll_watchdog.sv
// Watchdog: a down-counter reloaded by any register write (seen one cycle
// late so the freshly written timeout is used) or while disarmed. At zero it
// signals expiry for one cycle and starts a fixed-length reset pulse.
// Assumes timeout is stable except through register writes.
module pll_watchdog #(
    parameter int WT_W    = 12,
    parameter int RST_LEN = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            arm,
    input  logic            wr_seen,
    input  logic [WT_W-1:0] timeout,
    output logic            expire,
    output logic            sys_rst
);
    localparam int RC_W = $clog2(RST_LEN + 1);

    logic [WT_W-1:0] count;
    logic [RC_W-1:0] rst_cnt;
    logic            wr_q;

    // Expiry only when armed, counted out and no write in flight.
    assign expire  = arm && !wr_seen && !wr_q && (count == '0);
    assign sys_rst = (rst_cnt != '0);

    // Delay the write indication so the reload uses the new timeout.
    always_ff @(posedge clk) begin
        if (!rst_n) wr_q <= 1'b0;
        else        wr_q <= wr_seen;
    end

    // Timeout counter.
    always_ff @(posedge clk) begin
        if (!rst_n)                     count <= '0;
        else if (wr_q || !arm || expire) count <= timeout;
        else if (count != '0)           count <= count - 1'b1;
    end

    // Reset pulse length counter.
    always_ff @(posedge clk) begin
        if (!rst_n)              rst_cnt <= '0;
        else if (expire)         rst_cnt <= RC_W'(RST_LEN);
        else if (rst_cnt != '0)  rst_cnt <= rst_cnt - 1'b1;
    end

    p_rst_after_expire_r8: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> sys_rst);
    p_rst_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst) |-> $past(expire));
    p_no_expire_on_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_seen |-> !expire);
endmodule

// File: rtl/pll_cfg_regs.sv
// Configuration registers: control, dial-in dividers with staged M, link N,
// watchdog settings and recovery N. Applies the CPU recovery policy on a
// watchdog expiry. Assumes expiry never coincides with a write.
module pll_cfg_regs
    import pll_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wd_expire,
    output logic              cpu_daf_en,
    output logic              src_daf_en,
    output logic              sw_sel_en,
    output logic [SW_W-1:0]   sw_fsel,
    output logic [N_W-1:0]    daf_n,
    output logic [M_W-1:0]    daf_m,
    output logic [N_W-1:0]    src_daf_n,
    output logic              wd_en,
    output logic [TMO_W-1:0]  wd_timeout
);
    logic [M_W-1:0] m_pend;
    logic           m_pend_vld;
    logic [N_W-1:0] prev_n;
    logic [M_W-1:0] prev_m;
    logic [N_W-1:0] rec_n;
    logic           auto_en;
    rec_mode_e      rec_mode;
    logic           unused_data;

    assign unused_data = ^wr_data[DATA_W-1:7];

    // Register writes and watchdog recovery actions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpu_daf_en <= 1'b0;
            src_daf_en <= 1'b0;
            sw_sel_en  <= 1'b0;
            sw_fsel    <= '0;
            daf_n      <= '0;
            daf_m      <= '0;
            m_pend     <= '0;
            m_pend_vld <= 1'b0;
            prev_n     <= '0;
            prev_m     <= '0;
            src_daf_n  <= '0;
            rec_n      <= '0;
            wd_en      <= 1'b0;
            auto_en    <= 1'b0;
            rec_mode   <= REC_NONE;
            wd_timeout <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                A_CTRL: begin
                    cpu_daf_en <= wr_data[0];
                    src_daf_en <= wr_data[1];
                    sw_sel_en  <= wr_data[2];
                    sw_fsel    <= wr_data[3 +: SW_W];
                end
                A_CPU_N: begin
                    prev_n <= daf_n;
                    prev_m <= daf_m;
                    daf_n  <= wr_data[N_W-1:0];
                    if (m_pend_vld) begin
                        daf_m      <= m_pend;
                        m_pend_vld <= 1'b0;
                    end
                end
                A_CPU_M: begin
                    m_pend     <= wr_data[M_W-1:0];
                    m_pend_vld <= 1'b1;
                end
                A_SRC_N: src_daf_n <= wr_data[N_W-1:0];
                A_WDOG: begin
                    wd_en      <= wr_data[0];
                    auto_en    <= wr_data[1];
                    rec_mode   <= rec_mode_e'(wr_data[3:2]);
                    wd_timeout <= wr_data[4 +: TMO_W];
                end
                A_REC_N: rec_n <= wr_data[N_W-1:0];
                default: ;
            endcase
        end else if (wd_expire) begin
            if (auto_en) begin
                daf_n      <= prev_n;
                daf_m      <= prev_m;
                m_pend_vld <= 1'b0;
            end else begin
                case (rec_mode)
                    REC_MANUAL: daf_n      <= rec_n;
                    REC_HW:     cpu_daf_en <= 1'b0;
                    default:    ;
                endcase
            end
        end
    end

    p_m_with_n_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(daf_m) |-> ($past(wr_en && wr_addr == A_CPU_N) || $past(wd_expire && auto_en)));
    p_src_kept_r13: assert property (@(posedge clk) disable iff (!rst_n)
        wd_expire |=> $stable({src_daf_en, src_daf_n}));
    p_hw_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_expire && !auto_en && rec_mode == REC_HW) |=> !cpu_daf_en);
endmodule

// File: rtl/pll_div_ctrl.sv
// PLL divider controller top: picks table or dial-in dividers for the CPU and
// link PLLs, registers them with per-PLL change strobes, and arms a watchdog
// during CPU dial-in mode. Assumes hw_fsel is a static latched strap.
module pll_div_ctrl
    import pll_pkg::*;
#(
    parameter int RST_LEN = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [SEL_W-1:0]  hw_fsel,
    output logic [N_W-1:0]    cpu_n,
    output logic [M_W-1:0]    cpu_m,
    output logic [N_W-1:0]    src_n,
    output logic [M_W-1:0]    src_m,
    output logic [G_W-1:0]    gear,
    output logic              cpu_upd,
    output logic              src_upd,
    output logic              sys_rst
);
    logic              cpu_daf_en, src_daf_en, sw_sel_en, wd_en, wd_expire;
    logic [SW_W-1:0]   sw_fsel;
    logic [N_W-1:0]    daf_n, src_daf_n;
    logic [M_W-1:0]    daf_m;
    logic [TMO_W-1:0]  wd_timeout;
    logic [SEL_W-1:0]  cpu_sel;
    tbl_entry_t        cpu_ent, hw_ent;
    logic [N_W-1:0]    cpu_n_nx, src_n_nx;
    logic [M_W-1:0]    cpu_m_nx, src_m_nx;
    logic              unused_tbl;

    pll_cfg_regs i_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wd_expire(wd_expire), .cpu_daf_en(cpu_daf_en),
        .src_daf_en(src_daf_en), .sw_sel_en(sw_sel_en), .sw_fsel(sw_fsel),
        .daf_n(daf_n), .daf_m(daf_m), .src_daf_n(src_daf_n),
        .wd_en(wd_en), .wd_timeout(wd_timeout)
    );

    pll_watchdog #(.WT_W(TMO_W), .RST_LEN(RST_LEN)) i_wdog (
        .clk(clk), .rst_n(rst_n), .arm(wd_en && cpu_daf_en), .wr_seen(wr_en),
        .timeout(wd_timeout), .expire(wd_expire), .sys_rst(sys_rst)
    );

    // CPU row: software code when enabled, strap code otherwise.
    assign cpu_sel = sw_sel_en ? SEL_W'(sw_fsel) : hw_fsel;

    pll_freq_table i_cpu_tbl (.sel(cpu_sel), .entry(cpu_ent));
    pll_freq_table i_hw_tbl  (.sel(hw_fsel), .entry(hw_ent));

    assign unused_tbl = ^{cpu_ent.gear, cpu_ent.src_n, cpu_ent.src_m,
                          hw_ent.cpu_n, hw_ent.cpu_m};

    // Next divider values: dial-in registers or table row.
    always_comb begin
        cpu_n_nx = cpu_daf_en ? daf_n : cpu_ent.cpu_n;
        cpu_m_nx = cpu_daf_en ? daf_m : cpu_ent.cpu_m;
        src_n_nx = src_daf_en ? src_daf_n : hw_ent.src_n;
        src_m_nx = hw_ent.src_m;
    end

    // Output registers and change strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpu_n   <= '0;
            cpu_m   <= '0;
            src_n   <= '0;
            src_m   <= '0;
            gear    <= '0;
            cpu_upd <= 1'b0;
            src_upd <= 1'b0;
        end else begin
            cpu_n   <= cpu_n_nx;
            cpu_m   <= cpu_m_nx;
            src_n   <= src_n_nx;
            src_m   <= src_m_nx;
            gear    <= hw_ent.gear;
            cpu_upd <= ({cpu_n_nx, cpu_m_nx} != {cpu_n, cpu_m});
            src_upd <= ({src_n_nx, src_m_nx} != {src_n, src_m});
        end
    end

    p_cpu_upd_change_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_upd |-> !$stable({cpu_n, cpu_m}));
    p_cpu_quiet_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_upd |-> $stable({cpu_n, cpu_m}));
    p_src_upd_change_r7: assert property (@(posedge clk) disable iff (!rst_n)
        src_upd |-> !$stable({src_n, src_m}));
    p_src_quiet_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !src_upd |-> $stable({src_n, src_m}));
endmodule

// File: tb/test_pll_div_ctrl.sv
module test_pll_div_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [4:0]  hw_fsel = 5'd5;
    logic [8:0]  cpu_n, src_n;
    logic [6:0]  cpu_m, src_m;
    logic [7:0]  gear;
    logic        cpu_upd, src_upd, sys_rst;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    typedef struct packed {
        logic [8:0] cn;
        logic [6:0] cm;
        logic [8:0] sn;
        logic [6:0] sm;
    } item_t;
    item_t exp_q[$];
    string tag_q[$];

    always #10 clk = ~clk;

    pll_div_ctrl i_pll_div_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .hw_fsel(hw_fsel), .cpu_n(cpu_n), .cpu_m(cpu_m),
        .src_n(src_n), .src_m(src_m), .gear(gear), .cpu_upd(cpu_upd),
        .src_upd(src_upd), .sys_rst(sys_rst)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic push(input int cn, input int cm, input int sn, input int sm, input string tag);
        exp_q.push_back({9'(cn), 7'(cm), 9'(sn), 7'(sm)});
        tag_q.push_back(tag);
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'(a); wr_data = 16'(d);
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic drain(input string tag);
        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, tag, exp_q.size(), 0);
    endtask

    // Waits for sys_rst after a write, checking delay T+2 and width 16 (R8).
    task automatic wait_expiry(input int t, input string tag);
        int cnt = 0;
        int len = 0;
        while (!sys_rst && cnt < 500) begin
            @(posedge clk); @(negedge clk); cnt++;
        end
        check(cnt == t + 2, {tag, " R8 delay"}, cnt, t + 2);
        while (sys_rst && len < 100) begin
            @(posedge clk); @(negedge clk); len++;
        end
        check(len == 16, {tag, " R8 pulse"}, len, 16);
    endtask

    // Scoreboard monitor: every strobe must match the next expected item.
    always @(negedge clk) begin
        if (rst_n && (cpu_upd || src_upd)) begin
            item_t got, e;
            string tg;
            got = {cpu_n, cpu_m, src_n, src_m};
            if (exp_q.size() == 0) begin
                check(1'b0, "R7 unexpected strobe", int'(got), 0);
            end else begin
                e  = exp_q.pop_front();
                tg = tag_q.pop_front();
                check(got.cn == e.cn, {tg, " cpu_n"}, got.cn, e.cn);
                check(got.cm == e.cm, {tg, " cpu_m"}, got.cm, e.cm);
                check(got.sn == e.sn, {tg, " src_n"}, got.sn, e.sn);
                check(got.sm == e.sm, {tg, " src_m"}, got.sm, e.sm);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog timeout actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(cpu_n == 0 && cpu_m == 0 && src_n == 0 && gear == 0, "R1 outputs in reset", cpu_n, 0);
        check(!sys_rst && !cpu_upd && !src_upd, "R1 strobes in reset", sys_rst, 0);
        // Strap row 5.
        push(220, 29, 110, 26, "R1 first load");
        rst_n = 1'b1;
        drain("R1 drain");
        check(gear == 21, "R14 gear row 5", gear, 21);

        // Software select row 9.
        push(236, 25, 110, 26, "R2 sw select");
        wr(0, 76);
        drain("R2 drain");
        check(gear == 21, "R14 gear ignores sw select", gear, 21);

        // Dial-in pair, then enable.
        wr(2, 50);
        wr(1, 300);
        drain("R3 no change while disabled");
        push(300, 50, 110, 26, "R3 dial-in enable");
        wr(0, 77);
        drain("R3 drain");
        wr(2, 60);
        drain("R4 staged M no strobe");
        check(cpu_m == 50, "R4 M held", cpu_m, 50);
        push(310, 60, 110, 26, "R4 commit with N");
        wr(1, 310);
        drain("R4 drain");
        push(320, 60, 110, 26, "R5 N alone");
        wr(1, 320);
        drain("R5 drain");

        // Link dial-in and strap change.
        wr(3, 150);
        drain("R6 link N ignored while disabled");
        push(320, 60, 150, 26, "R6 link enable");
        wr(0, 79);
        drain("R6 drain");
        push(320, 60, 150, 27, "R6 link M follows strap");
        hw_fsel = 5'd6;
        drain("R6 strap drain");
        check(gear == 22, "R14 gear row 6", gear, 22);

        // Automatic recovery.
        wr(5, 400);
        push(310, 60, 150, 27, "R9 auto restore");
        wr(4, 643);
        wait_expiry(40, "R9");
        check(exp_q.size() == 0, "R9 strobe seen", exp_q.size(), 0);

        // Manual recovery.
        push(400, 60, 150, 27, "R10 manual N");
        wr(4, 645);
        wait_expiry(40, "R10");
        check(exp_q.size() == 0, "R10 strobe seen", exp_q.size(), 0);

        // Hardware recovery: back to software-selected row 9.
        push(236, 25, 150, 27, "R11 table again R13 link kept");
        wr(4, 649);
        wait_expiry(40, "R11");
        begin
            bit seen = 0;
            repeat (100) begin
                @(negedge clk);
                if (sys_rst) seen = 1;
            end
            check(!seen, "R8 disarmed without dial-in", seen, 0);
        end
        check(src_n == 150 && src_m == 27, "R13 link outputs", src_n, 150);

        // No recovery: pulse only.
        push(400, 60, 150, 27, "R12 dial-in again");
        wr(0, 79);
        wr(4, 641);
        wait_expiry(40, "R12");
        check(cpu_n == 400 && cpu_m == 60, "R12 dividers unchanged", cpu_n, 400);
        wr(4, 0);
        drain("R12 drain");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule